// File: doc/BRIEF.md
# Interval Count-Up Timer

This block is an interval timer whose count register climbs toward the top of its range and wraps. When it wraps, the count register is reloaded from a separate reload register. The block then records the event in a status register and can signal an interrupt. Software picks the interval by writing the two's complement of the wanted tick count into the reload register. It starts the timer by setting the transfer and run bits in the control/status register (CSR). While run is set, each tick input advances the count.

With run clear, the count can be advanced by hand one step at a time through a single-step bit. The status bits record wrap events. The done bit is set on the first wrap. The error bit is set instead when a wrap arrives while done is still set, which means a previous event was missed. Both status bits are cleared by writing a one to them. All registers share one write port and one combinational read port. The register map is: address 0 is the CSR, address 1 is the count (read only), address 2 is the reload register, and address 3 reads as zero.

Top module: `ivl_timer`

## Requirements
- R1: CSR bit layout: bit 0 run, bit 1 transfer, bit 2 single-step, bit 3 interrupt enable, bit 6 done, bit 7 error. Run and interrupt enable take the written value and read back. Transfer and single-step act only in the cycle of the write and read as 0. All CSR bits are 0 after reset, and so are the count, the reload register and `irq_o`.
- R2: Writing a 1 to done (bit 6) or error (bit 7) clears that bit. Writing a 0 leaves it unchanged.
- R3: A CSR write with transfer set copies the reload register into the count register.
- R4: A CSR write with single-step set and the written run bit clear adds one to the count. If transfer is also set, the one is added to the transferred value. With the written run bit set, single-step has no effect.
- R5: On a wrap to zero, the error bit is set if done is set at that moment, after any clear in the same write. Otherwise the done bit is set.
- R6: On a wrap, the count register loads the value that the reload register held before that clock edge.
- R7: A wrap raises `irq_o` one cycle later if interrupt enable is set, including when it is set by that same write. Setting interrupt enable later, while done is already set, does not raise `irq_o`.
- R8: `irq_o` falls as soon as done and interrupt enable are not both set.
- R9: The interval is 2^32 minus the reload value, in ticks. A reload value of 0 gives the full 2^32 ticks, so its first tick takes the count from 0 to 1.
- R10: While run is set, each cycle with `tick_i` high adds one to the count. While run is clear, ticks are ignored and the count holds its value.
- R11: A tick in the same cycle as a CSR write is ignored.
- R12: The count register reads its current value at address 1, and writes to it are ignored. The reload register is read and written at address 2. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count tick, one per cycle it is high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data for `rd_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences cover the cases that tell the overflow outcomes apart:
- a first wrap, which sets done;
- a second wrap with done still set, which sets error;
- a wrap caused by a single-step write that also transfers;
- a reload of zero, which must not wrap on its first tick.

Further directed cases separate ticks taken while running from ticks ignored while stopped or during a CSR write.

Random stimulus then mixes ticks, CSR writes with random bit patterns and reload values close to the top of the range, so that wraps are frequent. This exposes the order between W1C clears, transfer, stepping and wrap handling. After every cycle, all registers and `irq_o` are compared against a reference model in the bench.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
   localparam int unsigned ADDR_W   = 2;
   localparam logic [ADDR_W-1:0] A_CSR    = 2'd0;
   localparam logic [ADDR_W-1:0] A_COUNT  = 2'd1;
   localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;

   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_XFER = 1;
   localparam int unsigned B_STEP = 2;
   localparam int unsigned B_IE   = 3;
   localparam int unsigned B_DONE = 6;
   localparam int unsigned B_ERR  = 7;
   localparam int unsigned CSR_MSB = B_ERR;

   typedef struct packed {
      logic err;
      logic done;
      logic ie;
      logic run;
   } ctrl_state_t;
endpackage

// File: rtl/ivl_tick_gate.sv
module ivl_tick_gate #(
   parameter bit EDGE_MODE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic tick_o
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic tick_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_d <= 1'b0;
            else        tick_d <= tick_i;
         end
         assign tick_o = tick_i & ~tick_d;
      end else begin : g_level
         assign tick_o = tick_i;
      end
   endgenerate
endmodule

// File: rtl/ivl_count.sv
module ivl_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   sum;

   assign base   = xfer_i ? reload_i : cnt_q;
   assign sum    = {1'b0, base} + {{CNT_W{1'b0}}, 1'b1};
   assign wrap_o = inc_i & sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= sum[CNT_W] ? reload_i : sum[CNT_W-1:0];
      end else if (xfer_i) begin
         cnt_q <= reload_i;
      end
   end

   assign count_o = cnt_q;

   AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> cnt_q == $past(reload_i)); // R6
   AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_i && !inc_i) |=> cnt_q == $past(reload_i)); // R3
endmodule

// File: rtl/ivl_ctrl.sv
module ivl_ctrl
   import ivl_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              tick_i,
   input  logic              wrap_i,
   output logic              xfer_o,
   output logic              inc_o,
   output ctrl_state_t       st_o,
   output logic              irq_o
);
   ctrl_state_t st_q, st_n;
   logic        irq_q, irq_n;
   logic        done_kept, err_kept;

   assign xfer_o = csr_wr_i & wdata_i[B_XFER];
   assign inc_o  = csr_wr_i ? (wdata_i[B_STEP] & ~wdata_i[B_RUN])
                            : (st_q.run & tick_i);

   assign done_kept = st_q.done & ~(csr_wr_i & wdata_i[B_DONE]);
   assign err_kept  = st_q.err  & ~(csr_wr_i & wdata_i[B_ERR]);

   always_comb begin
      st_n      = st_q;
      st_n.done = done_kept;
      st_n.err  = err_kept;
      if (csr_wr_i) begin
         st_n.run = wdata_i[B_RUN];
         st_n.ie  = wdata_i[B_IE];
      end
      if (wrap_i) begin
         if (done_kept) st_n.err  = 1'b1;
         else           st_n.done = 1'b1;
      end
      irq_n = (irq_q | (wrap_i & st_n.ie)) & st_n.done & st_n.ie;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         irq_q <= irq_n;
      end
   end

   assign st_o  = st_q;
   assign irq_o = irq_q;

   AST_WRAP_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> st_q.done); // R5
   AST_MISSED_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && st_q.done && !csr_wr_i) |=> st_q.err); // R5
   AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (st_q.done && st_q.ie)); // R8
   AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_i && (csr_wr_i ? wdata_i[B_IE] : st_q.ie)) |=> irq_q); // R7
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
   import ivl_timer_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter bit          EDGE_TICK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [1:0]       rd_addr_i,
   output logic [CNT_W-1:0] rd_data_o,
   output logic             irq_o
);
   localparam int unsigned PAD_W = CNT_W - (CSR_MSB + 1);

   generate
      if (CNT_W < CSR_MSB + 1 || CNT_W > 64) begin : g_bad_width
         $error("ivl_timer: CNT_W must lie between %0d and 64", CSR_MSB + 1);
      end
   endgenerate

   logic             tick_g, csr_wr, rel_wr, xfer, inc, wrap;
   logic [CNT_W-1:0] count, reload_q;
   ctrl_state_t      st;
   logic [CSR_MSB:0] csr_rd;

   assign csr_wr = wr_en_i && (wr_addr_i == A_CSR);
   assign rel_wr = wr_en_i && (wr_addr_i == A_RELOAD);

   ivl_tick_gate #(.EDGE_MODE(EDGE_TICK)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tick_o(tick_g));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reload_q <= '0;
      else if (rel_wr) reload_q <= wr_data_i;
   end

   ivl_ctrl #(.DATA_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .csr_wr_i(csr_wr), .wdata_i(wr_data_i),
      .tick_i(tick_g), .wrap_i(wrap), .xfer_o(xfer), .inc_o(inc),
      .st_o(st), .irq_o(irq_o));

   ivl_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .inc_i(inc),
      .reload_i(reload_q), .count_o(count), .wrap_o(wrap));

   always_comb begin
      csr_rd         = '0;
      csr_rd[B_RUN]  = st.run;
      csr_rd[B_IE]   = st.ie;
      csr_rd[B_DONE] = st.done;
      csr_rd[B_ERR]  = st.err;
      unique case (rd_addr_i)
         A_CSR:    rd_data_o = {{PAD_W{1'b0}}, csr_rd};
         A_COUNT:  rd_data_o = count;
         A_RELOAD: rd_data_o = reload_q;
         default:  rd_data_o = '0;
      endcase
   end

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!st.run && !csr_wr) |=> $stable(count)); // R10
   AST_WRITE_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && !wr_data_i[B_XFER] && !wr_data_i[B_STEP]) |=> $stable(count)); // R11
endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_addr_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [1:0]  rd_addr_i = '0;
   logic [31:0] rd_data_o;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_cnt, m_rel;
   logic        m_run, m_ie, m_done, m_err, m_irq;

   always #10 clk = ~clk;

   ivl_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .irq_o(irq_o));

   function automatic logic [31:0] m_csr();
      return {24'd0, m_err, m_done, 2'b00, m_ie, 2'b00, m_run};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr_i = a;
      #1 v = rd_data_o;
   endtask

   function automatic void model(input logic w, input logic [1:0] a,
                                 input logic [31:0] d, input logic t);
      logic csr, ovf, inc, dn, er, ie_n;
      logic [32:0] s;
      logic [31:0] base;
      csr = w && a == 2'd0;
      ovf = 1'b0;
      dn = m_done; er = m_err; ie_n = m_ie;
      base = m_cnt;
      if (csr) begin
         dn = m_done & ~d[6];
         er = m_err & ~d[7];
         ie_n = d[3];
         m_run = d[0];
         if (d[1]) base = m_rel;
         inc = d[2] & ~d[0];
      end else begin
         inc = m_run & t;
      end
      if (inc) begin
         s = {1'b0, base} + 33'd1;
         ovf = s[32];
         m_cnt = ovf ? m_rel : s[31:0];
      end else begin
         m_cnt = base;
      end
      if (ovf) begin
         if (dn) er = 1'b1; else dn = 1'b1;
      end
      m_irq = (m_irq | (ovf & ie_n)) & dn & ie_n;
      m_done = dn; m_err = er; m_ie = ie_n;
      if (w && a == 2'd2) m_rel = d;
   endfunction

   task automatic check_all(input string tag);
      logic [31:0] v;
      rd(2'd0, v); chk({tag, " csr"}, v, m_csr());
      rd(2'd1, v); chk({tag, " count"}, v, m_cnt);
      rd(2'd2, v); chk({tag, " reload"}, v, m_rel);
      chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
   endtask

   task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d, input logic t);
      @(negedge clk);
      wr_en_i = w; wr_addr_i = a; wr_data_i = d; tick_i = t;
      @(posedge clk);
      model(w, a, d, t);
      @(negedge clk);
      wr_en_i = 1'b0; tick_i = 1'b0;
      check_all("model");
   endtask

   task automatic expect_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      void'($urandom(32'h5EED_1234));
      m_cnt = 0; m_rel = 0; m_run = 0; m_ie = 0; m_done = 0; m_err = 0; m_irq = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_reg("R1 reset csr", 2'd0, 32'h0);
      expect_reg("R1 reset count", 2'd1, 32'h0);
      expect_reg("R1 reset reload", 2'd2, 32'h0);
      chk("R1 reset irq", {31'd0, irq_o}, 32'd0);

      cyc(1, 2'd2, 32'hFFFF_FFFD, 0);
      expect_reg("R12 reload readback", 2'd2, 32'hFFFF_FFFD);
      cyc(1, 2'd1, 32'h0000_0123, 0);
      expect_reg("R12 count write ignored", 2'd1, 32'h0);
      cyc(1, 2'd0, 32'h2, 0);
      expect_reg("R3 transfer", 2'd1, 32'hFFFF_FFFD);
      expect_reg("R1 transfer reads zero", 2'd0, 32'h0);
      cyc(1, 2'd0, 32'h9, 0);
      expect_reg("R1 run and ie", 2'd0, 32'h9);
      cyc(0, 2'd0, 0, 1);
      cyc(0, 2'd0, 0, 1);
      expect_reg("R10 running ticks", 2'd1, 32'hFFFF_FFFF);
      cyc(0, 2'd0, 0, 1);
      expect_reg("R9 R6 wrap after three ticks", 2'd1, 32'hFFFF_FFFD);
      expect_reg("R5 done on first wrap", 2'd0, 32'h49);
      chk("R7 irq on wrap", {31'd0, irq_o}, 32'd1);
      repeat (3) cyc(0, 2'd0, 0, 1);
      expect_reg("R5 error on missed done", 2'd0, 32'hC9);
      cyc(1, 2'd0, 32'h49, 0);
      expect_reg("R2 done cleared error kept", 2'd0, 32'h89);
      chk("R8 irq drops with done", {31'd0, irq_o}, 32'd0);
      cyc(1, 2'd0, 32'h89, 1);
      expect_reg("R11 tick during write ignored", 2'd1, 32'hFFFF_FFFD);
      expect_reg("R2 error cleared", 2'd0, 32'h09);
      cyc(1, 2'd0, 32'h08, 0);
      cyc(0, 2'd0, 0, 1);
      cyc(0, 2'd0, 0, 1);
      expect_reg("R10 stopped count frozen", 2'd1, 32'hFFFF_FFFD);
      cyc(1, 2'd0, 32'h0C, 0);
      expect_reg("R4 single step", 2'd1, 32'hFFFF_FFFE);
      expect_reg("R1 step reads zero", 2'd0, 32'h08);
      cyc(1, 2'd0, 32'h0D, 0);
      expect_reg("R4 step ignored with run", 2'd1, 32'hFFFF_FFFE);
      cyc(1, 2'd0, 32'h0C, 0);
      cyc(1, 2'd0, 32'h0C, 0);
      expect_reg("R6 step wrap reloads", 2'd1, 32'hFFFF_FFFD);
      chk("R7 irq on step wrap", {31'd0, irq_o}, 32'd1);
      cyc(1, 2'd0, 32'h40, 0);
      chk("R8 irq drops with ie", {31'd0, irq_o}, 32'd0);
      cyc(1, 2'd2, 32'hFFFF_FFFF, 0);
      cyc(1, 2'd0, 32'h06, 0);
      expect_reg("R3 R4 transfer plus step wraps", 2'd1, 32'hFFFF_FFFF);
      expect_reg("R5 done from step wrap", 2'd0, 32'h40);
      chk("R7 no irq without ie", {31'd0, irq_o}, 32'd0);
      cyc(1, 2'd0, 32'h08, 0);
      chk("R7 late ie raises nothing", {31'd0, irq_o}, 32'd0);
      cyc(1, 2'd0, 32'h40, 0);
      cyc(1, 2'd2, 32'h0, 0);
      cyc(1, 2'd0, 32'h03, 0);
      cyc(0, 2'd0, 0, 1);
      expect_reg("R9 zero reload first tick", 2'd1, 32'h1);
      expect_reg("R9 zero reload no wrap", 2'd0, 32'h01);
      expect_reg("R12 address three zero", 2'd3, 32'h0);

      for (int i = 0; i < 3000; i++) begin
         int unsigned op;
         op = $urandom % 8;
         if (op < 4) begin
            cyc(0, 2'd0, 0, 1);
         end else if (op == 4) begin
            r = ($urandom % 6 == 0) ? 32'h0 : (32'hFFFF_FFF0 | ($urandom & 32'hF));
            cyc(1, 2'd2, r, $urandom % 2 == 1);
         end else begin
            r = $urandom & 32'hCF;
            if ($urandom % 3 != 0) r[0] = 1'b1;
            cyc(1, 2'd0, r, $urandom % 2 == 1);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule